// File: doc/BRIEF.md
# Cascaded Card-Host Interrupt Aggregator

This block gathers the interrupt events of a storage-card host and merges them with the request of a sibling controller onto one interrupt line. It has two levels. At the local level each event pulse sets a sticky status bit, and a matching enable bit decides whether that bit counts toward the host's request. At the global level one sticky bit records the host request and a second records the sibling request. Each global bit reaches the output only when both its status-enable bit and its signal-enable bit are set.

Software reaches every register through a plain word-addressed port with address, write data, a write strobe and combinational read data. Both status registers are cleared by writing ones, so a handler can read a status word and write the same value back. Turning off both global enables silences the line and keeps all pending status. Status latching never depends on any enable, so a masked source can still be seen as pending.

Top module: `irq_cascade`

## Requirements
- R1: After reset every register reads zero and `irq_o` is low.
- R2: A one-cycle pulse on an implemented event input sets its local status bit (address 0) at the next clock whatever the enables hold. The implemented bits are 0, 1, 2, 3, 8, 9, 10 and 11. Bits 4 to 7 and bits 12 and up never set and always read 0.
- R3: Writing to address 0 clears each local status bit written as 1 and leaves every bit written as 0 unchanged. Writing back the value just read clears the whole word.
- R4: When an event pulse and a write-1-to-clear hit the same local bit in the same cycle, the bit stays set.
- R5: The local enable register (address 1) stores written values only in the implemented bit positions. Other positions read 0.
- R6: Global status bit 0 (address 2) is set one clock after any local bit is both pending and enabled. While that condition holds, a write-1-to-clear of bit 0 has no effect. Once the condition is gone, bit 0 stays set until it is cleared.
- R7: A pulse on `sib_evt_i` sets global status bit 1. Writing 1 to bit 1 clears it, unless a pulse arrives in the same cycle, in which case the bit stays set.
- R8: `irq_o` is active high and registered. It goes high one clock after some global status bit has its status-enable bit (address 3) and its signal-enable bit (address 4) both set, and falls one clock after no bit meets that condition.
- R9: Writing 0 to both global enable registers drops `irq_o` and leaves the local and global status unchanged.
- R10: The global registers hold only bits 1:0, and upper bits read 0. Addresses 5 to 7 read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W (3) | Register word address |
| wdata_i | input | DATA_W (32) | Write data |
| wr_i | input | 1 | Write strobe, one write per high cycle |
| rdata_o | output | DATA_W (32) | Read data for `addr_i`, combinational |
| evt_i | input | LOCAL_W (12) | One-cycle event pulses, one per local bit |
| sib_evt_i | input | 1 | One-cycle request pulse from the sibling controller |
| irq_o | output | 1 | Merged interrupt, registered, active high |

## Verification
Two pairs of actions can land in the same cycle. The first is an event pulse and a write-1-to-clear of the same bit, at either level. The second is a clear of global bit 0 while the local request is still asserted. The bench drives each pair on a single clock edge, then reads the register back. It judges the result against a behavioural model in which setting always beats clearing. A held request must survive the clear and remain cleared only after the local bit has been acknowledged.

// File: rtl/irq_cascade_pkg.sv
package irq_cascade_pkg;

    // word addresses of the register port
    localparam int REG_LOC_STAT  = 0;
    localparam int REG_LOC_EN    = 1;
    localparam int REG_GLB_STAT  = 2;
    localparam int REG_GLB_SEN   = 3;
    localparam int REG_GLB_SIG   = 4;

    // global source positions
    localparam int GSRC_HOST     = 0;
    localparam int GSRC_SIBLING  = 1;

endpackage

// File: rtl/irq_regsel.sv
module irq_regsel
    import irq_cascade_pkg::*;
#(
    parameter int ADDR_W   = 3,
    parameter int DATA_W   = 32,
    parameter int LOCAL_W  = 12,
    parameter int GLOBAL_W = 2
) (
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic                wr_i,
    input  logic [LOCAL_W-1:0]  loc_stat_i,
    input  logic [LOCAL_W-1:0]  loc_en_i,
    input  logic [GLOBAL_W-1:0] glb_stat_i,
    input  logic [GLOBAL_W-1:0] glb_sen_i,
    input  logic [GLOBAL_W-1:0] glb_sig_i,
    output logic                loc_stat_wr_o,
    output logic                loc_en_wr_o,
    output logic                glb_stat_wr_o,
    output logic                glb_sen_wr_o,
    output logic                glb_sig_wr_o,
    output logic [DATA_W-1:0]   rdata_o
);

    logic hit_lstat, hit_len, hit_gstat, hit_gsen, hit_gsig;

    always_comb begin
        hit_lstat = (addr_i == ADDR_W'(REG_LOC_STAT));
        hit_len   = (addr_i == ADDR_W'(REG_LOC_EN));
        hit_gstat = (addr_i == ADDR_W'(REG_GLB_STAT));
        hit_gsen  = (addr_i == ADDR_W'(REG_GLB_SEN));
        hit_gsig  = (addr_i == ADDR_W'(REG_GLB_SIG));

        loc_stat_wr_o = wr_i & hit_lstat;
        loc_en_wr_o   = wr_i & hit_len;
        glb_stat_wr_o = wr_i & hit_gstat;
        glb_sen_wr_o  = wr_i & hit_gsen;
        glb_sig_wr_o  = wr_i & hit_gsig;

        rdata_o = '0;
        if (hit_lstat) rdata_o = DATA_W'(loc_stat_i);
        if (hit_len)   rdata_o = DATA_W'(loc_en_i);
        if (hit_gstat) rdata_o = DATA_W'(glb_stat_i);
        if (hit_gsen)  rdata_o = DATA_W'(glb_sen_i);
        if (hit_gsig)  rdata_o = DATA_W'(glb_sig_i);
    end

    // a write strobe never reaches two registers at once
    always_comb begin
        assert_one_target_R10: assert ($onehot0({loc_stat_wr_o, loc_en_wr_o,
                                                 glb_stat_wr_o, glb_sen_wr_o,
                                                 glb_sig_wr_o}));
    end

endmodule

// File: rtl/irq_local_bank.sv
module irq_local_bank #(
    parameter int               LOCAL_W   = 12,
    parameter logic [LOCAL_W-1:0] IMPL_MASK = 12'hF0F
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [LOCAL_W-1:0] evt_i,
    input  logic               stat_wr_i,
    input  logic               en_wr_i,
    input  logic [LOCAL_W-1:0] wdata_i,
    output logic [LOCAL_W-1:0] stat_o,
    output logic [LOCAL_W-1:0] en_o,
    output logic               req_o
);

    typedef struct packed {
        logic [LOCAL_W-1:0] stat;
        logic [LOCAL_W-1:0] en;
    } loc_state_t;

    loc_state_t st_d, st_q;
    logic [LOCAL_W-1:0] stat_next;
    logic [LOCAL_W-1:0] clr_mask;

    assign clr_mask = stat_wr_i ? wdata_i : '0;

    // one sticky cell per implemented position, constant zero elsewhere
    for (genvar b = 0; b < LOCAL_W; b++) begin : g_bit
        if (IMPL_MASK[b]) begin : g_impl
            assign stat_next[b] = evt_i[b] | (st_q.stat[b] & ~clr_mask[b]);
        end else begin : g_hole
            assign stat_next[b] = 1'b0;
        end
    end

    always_comb begin
        st_d      = st_q;
        st_d.stat = stat_next;
        if (en_wr_i) begin
            st_d.en = wdata_i & IMPL_MASK;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat_o = st_q.stat;
    assign en_o   = st_q.en;
    assign req_o  = |(st_q.stat & st_q.en);

    // an implemented event always lands, enables or not
    assert_evt_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|(evt_i & IMPL_MASK)) |=>
        ((stat_o & $past(evt_i & IMPL_MASK)) == $past(evt_i & IMPL_MASK)));

    // written ones without a coincident event are gone next cycle
    assert_w1c_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stat_wr_i |=> ((stat_o & $past(wdata_i & ~evt_i)) == '0));

    // with no write, pending bits never drop
    assert_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !stat_wr_i |=> ((stat_o & $past(stat_o)) == $past(stat_o)));

    // collision: event beats clear
    assert_evt_wins_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stat_wr_i && (|(evt_i & wdata_i & IMPL_MASK))) |=>
        ((stat_o & $past(evt_i & wdata_i & IMPL_MASK)) != '0));

endmodule

// File: rtl/irq_global_bank.sv
module irq_global_bank #(
    parameter int GLOBAL_W = 2
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [GLOBAL_W-1:0] src_i,
    input  logic                stat_wr_i,
    input  logic                sen_wr_i,
    input  logic                sig_wr_i,
    input  logic [GLOBAL_W-1:0] wdata_i,
    output logic [GLOBAL_W-1:0] stat_o,
    output logic [GLOBAL_W-1:0] sen_o,
    output logic [GLOBAL_W-1:0] sig_o,
    output logic                irq_o
);

    typedef struct packed {
        logic [GLOBAL_W-1:0] stat;
        logic [GLOBAL_W-1:0] sen;
        logic [GLOBAL_W-1:0] sig;
        logic                irq;
    } glb_state_t;

    glb_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.stat = src_i | (st_q.stat & ~(stat_wr_i ? wdata_i : '0));
        if (sen_wr_i) st_d.sen = wdata_i;
        if (sig_wr_i) st_d.sig = wdata_i;
        st_d.irq  = |(st_q.stat & st_q.sen & st_q.sig);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat_o = st_q.stat;
    assign sen_o  = st_q.sen;
    assign sig_o  = st_q.sig;
    assign irq_o  = st_q.irq;

    // a source asserted in a cycle is recorded, even against a clear
    assert_src_sets_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|src_i) |=> ((stat_o & $past(src_i)) == $past(src_i)));

    // no source passes both masks: line is quiet next cycle
    assert_silence_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((sen_o & sig_o) == '0) |=> !irq_o);

    // the line is only ever raised by pending global status
    assert_irq_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> $past(|stat_o));

endmodule

// File: rtl/irq_cascade.sv
module irq_cascade
    import irq_cascade_pkg::*;
#(
    parameter int               ADDR_W     = 3,
    parameter int               DATA_W     = 32,
    parameter int               LOCAL_W    = 12,
    parameter logic [LOCAL_W-1:0] LOCAL_IMPL = 12'hF0F,
    parameter int               GLOBAL_W   = 2
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [DATA_W-1:0]  wdata_i,
    input  logic               wr_i,
    output logic [DATA_W-1:0]  rdata_o,
    input  logic [LOCAL_W-1:0] evt_i,
    input  logic               sib_evt_i,
    output logic               irq_o
);

    localparam int SRC_PAD = GLOBAL_W - 2;

    logic                loc_stat_wr, loc_en_wr;
    logic                glb_stat_wr, glb_sen_wr, glb_sig_wr;
    logic [LOCAL_W-1:0]  loc_stat, loc_en;
    logic                host_req;
    logic [GLOBAL_W-1:0] glb_stat, glb_sen, glb_sig;
    logic [GLOBAL_W-1:0] glb_src;
    logic                unused_wdata_hi;

    assign unused_wdata_hi = ^wdata_i[DATA_W-1:LOCAL_W];

    always_comb begin
        glb_src               = '0;
        glb_src[GSRC_HOST]    = host_req;
        glb_src[GSRC_SIBLING] = sib_evt_i;
    end

    irq_regsel #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .LOCAL_W  (LOCAL_W),
        .GLOBAL_W (GLOBAL_W)
    ) u_regsel (
        .addr_i        (addr_i),
        .wr_i          (wr_i),
        .loc_stat_i    (loc_stat),
        .loc_en_i      (loc_en),
        .glb_stat_i    (glb_stat),
        .glb_sen_i     (glb_sen),
        .glb_sig_i     (glb_sig),
        .loc_stat_wr_o (loc_stat_wr),
        .loc_en_wr_o   (loc_en_wr),
        .glb_stat_wr_o (glb_stat_wr),
        .glb_sen_wr_o  (glb_sen_wr),
        .glb_sig_wr_o  (glb_sig_wr),
        .rdata_o       (rdata_o)
    );

    irq_local_bank #(
        .LOCAL_W   (LOCAL_W),
        .IMPL_MASK (LOCAL_IMPL)
    ) u_local (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .evt_i     (evt_i),
        .stat_wr_i (loc_stat_wr),
        .en_wr_i   (loc_en_wr),
        .wdata_i   (wdata_i[LOCAL_W-1:0]),
        .stat_o    (loc_stat),
        .en_o      (loc_en),
        .req_o     (host_req)
    );

    irq_global_bank #(
        .GLOBAL_W (GLOBAL_W)
    ) u_global (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .src_i     (glb_src),
        .stat_wr_i (glb_stat_wr),
        .sen_wr_i  (glb_sen_wr),
        .sig_wr_i  (glb_sig_wr),
        .wdata_i   (wdata_i[GLOBAL_W-1:0]),
        .stat_o    (glb_stat),
        .sen_o     (glb_sen),
        .sig_o     (glb_sig),
        .irq_o     (irq_o)
    );

    // a held host request keeps the global host bit set, clears notwithstanding
    assert_host_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        host_req |=> glb_stat[GSRC_HOST]);

    // pending local status is untouched by global enable writes
    assert_local_kept_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((glb_sen_wr || glb_sig_wr) && !loc_stat_wr) |=>
        ((loc_stat & $past(loc_stat)) == $past(loc_stat)));

    initial begin
        assert_pad_R10: assert (SRC_PAD >= 0);
    end

endmodule

// File: tb/irq_cascade_test.sv
`timescale 1ns/100ps
module irq_cascade_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        wr = 1'b0;
    logic [31:0] rdata;
    logic [11:0] evt = '0;
    logic        sib = 1'b0;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;
    string cur_req = "R1";
    bit done = 0;

    always #2.5 clk = ~clk;

    irq_cascade uut (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .addr_i    (addr),
        .wdata_i   (wdata),
        .wr_i      (wr),
        .rdata_o   (rdata),
        .evt_i     (evt),
        .sib_evt_i (sib),
        .irq_o     (irq)
    );

    // behavioural reference
    int m_lstat, m_len, m_gstat, m_gsen, m_gsig;
    bit m_irq;
    localparam int IMPL = 'hF0F;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_lstat = 0; m_len = 0; m_gstat = 0; m_gsen = 0; m_gsig = 0; m_irq = 0;
        end else begin
            int clr_l, clr_g, n_lstat, n_len, n_gstat, n_gsen, n_gsig;
            bit hreq, n_irq;
            clr_l = (wr && addr == 0) ? int'(wdata) : 0;
            clr_g = (wr && addr == 2) ? int'(wdata) : 0;
            hreq  = (m_lstat & m_len) != 0;
            n_lstat = ((m_lstat & ~clr_l) | int'(evt)) & IMPL;
            n_len   = (wr && addr == 1) ? (int'(wdata) & IMPL) : m_len;
            n_gstat = ((m_gstat & ~clr_g) | (hreq ? 1 : 0) | (sib ? 2 : 0)) & 3;
            n_gsen  = (wr && addr == 3) ? (int'(wdata) & 3) : m_gsen;
            n_gsig  = (wr && addr == 4) ? (int'(wdata) & 3) : m_gsig;
            n_irq   = (m_gstat & m_gsen & m_gsig) != 0;
            m_lstat = n_lstat; m_len = n_len; m_gstat = n_gstat;
            m_gsen = n_gsen; m_gsig = n_gsig; m_irq = n_irq;
        end
    end

    function automatic int model_rd(input int a);
        case (a)
            0: return m_lstat;
            1: return m_len;
            2: return m_gstat;
            3: return m_gsen;
            4: return m_gsig;
            default: return 0;
        endcase
    endfunction

    // every-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            n_checks++;
            if (irq !== m_irq) begin
                n_fail++;
                $display("FAIL %s irq_o actual=%0b expected=%0b t=%0t", cur_req, irq, m_irq, $time);
            end
            n_checks++;
            if (rdata !== 32'(model_rd(int'(addr)))) begin
                n_fail++;
                $display("FAIL %s rdata[addr %0d] actual=%h expected=%h", cur_req, addr, rdata, model_rd(int'(addr)));
            end
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic wr_reg(input int a, input logic [31:0] d);
        addr = 3'(a); wdata = d; wr = 1'b1;
        tick();
        wr = 1'b0; wdata = '0;
    endtask

    task automatic pulse(input logic [11:0] e, input logic s);
        evt = e; sib = s;
        tick();
        evt = '0; sib = 1'b0;
    endtask

    task automatic clash(input int a, input logic [31:0] d, input logic [11:0] e, input logic s);
        addr = 3'(a); wdata = d; wr = 1'b1; evt = e; sib = s;
        tick();
        wr = 1'b0; wdata = '0; evt = '0; sib = 1'b0;
    endtask

    task automatic chk_rd(input int a, input logic [31:0] exp);
        addr = 3'(a);
        @(negedge clk);
        n_checks++;
        if (rdata !== exp) begin
            n_fail++;
            $display("FAIL %s read addr %0d actual=%h expected=%h", cur_req, a, rdata, exp);
        end
        tick();
    endtask

    task automatic chk_irq(input logic exp);
        @(negedge clk);
        n_checks++;
        if (irq !== exp) begin
            n_fail++;
            $display("FAIL %s irq_o actual=%0b expected=%0b", cur_req, irq, exp);
        end
        tick();
    endtask

    task automatic finish_run();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog %s expired", cur_req);
            finish_run();
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        tick();

        cur_req = "R1";
        for (int a = 0; a < 5; a++) chk_rd(a, 32'h0);
        chk_irq(1'b0);

        cur_req = "R2";
        pulse(12'hFFF, 1'b0);
        chk_rd(0, 32'h0000_0F0F);
        chk_irq(1'b0);

        cur_req = "R3";
        wr_reg(0, 32'h0);
        chk_rd(0, 32'h0000_0F0F);
        wr_reg(0, 32'h0000_000F);
        chk_rd(0, 32'h0000_0F00);
        wr_reg(0, 32'h0000_0F00);
        chk_rd(0, 32'h0);

        cur_req = "R4";
        pulse(12'h200, 1'b0);
        clash(0, 32'h0000_0200, 12'h200, 1'b0);
        chk_rd(0, 32'h0000_0200);
        wr_reg(0, 32'h0000_0200);
        chk_rd(0, 32'h0);

        cur_req = "R5";
        wr_reg(1, 32'hFFFF_FFFF);
        chk_rd(1, 32'h0000_0F0F);
        wr_reg(1, 32'h0000_0200);
        chk_rd(1, 32'h0000_0200);

        cur_req = "R6";
        pulse(12'h001, 1'b0);
        idle(2);
        chk_rd(2, 32'h0);
        pulse(12'h200, 1'b0);
        idle(2);
        chk_rd(2, 32'h1);
        wr_reg(2, 32'h1);
        chk_rd(2, 32'h1);
        wr_reg(0, 32'h0000_0201);
        idle(2);
        chk_rd(2, 32'h1);
        wr_reg(2, 32'h1);
        chk_rd(2, 32'h0);

        cur_req = "R7";
        pulse(12'h0, 1'b1);
        chk_rd(2, 32'h2);
        clash(2, 32'h2, 12'h0, 1'b1);
        chk_rd(2, 32'h2);
        wr_reg(2, 32'h2);
        chk_rd(2, 32'h0);

        cur_req = "R8";
        wr_reg(3, 32'h3);
        wr_reg(4, 32'h1);
        pulse(12'h200, 1'b0);
        idle(3);
        chk_irq(1'b1);
        wr_reg(4, 32'h2);
        idle(1);
        chk_irq(1'b0);
        pulse(12'h0, 1'b1);
        idle(2);
        chk_irq(1'b1);

        cur_req = "R9";
        wr_reg(3, 32'h0);
        wr_reg(4, 32'h0);
        idle(1);
        chk_irq(1'b0);
        chk_rd(0, 32'h0000_0200);
        chk_rd(2, 32'h3);

        cur_req = "R10";
        wr_reg(3, 32'hFFFF_FFFF);
        chk_rd(3, 32'h3);
        chk_rd(5, 32'h0);
        chk_rd(7, 32'h0);
        wr_reg(6, 32'hFFFF_FFFF);
        chk_rd(1, 32'h0000_0200);
        chk_rd(4, 32'h0);
        chk_rd(0, 32'h0000_0200);

        idle(2);
        finish_run();
    end

endmodule